// File: doc/BRIEF.md
# Command Register Bridge Target

This block sits on a simple 64-bit register port as a slave and converts single register writes into transactions on a downstream 32-bit peripheral bus. Software writes one 64-bit command word that holds the direction, the access size, a 24-bit downstream address and, for writes, the data. The block holds a request towards the peripheral bus until that bus acknowledges, reports an error, or fails to answer within a fixed number of cycles.

Software then polls one 64-bit status word. That word holds, all at once, the busy flag, a read-data-valid flag, three groups of sticky error flags and the captured read data. Writing zero to the status word clears it. A third register keeps a copy of the status word as it stood when the most recent transaction finished. The two master-error groups come from two neighbouring master channels as per-cycle pulses. The block only gathers them and does not act on them.

Top module: `cmd_bridge_target`

## Requirements
- R1: `reg_sel` picks the register. 0 is the command register and reads back the last accepted command. 1 is the status word. 2 is the last-status copy. 3 reads as zero. Writes to select 2 or 3 change nothing. After reset every register reads zero and `dn_req` is low.
- R2: A command write while the block is idle sets busy (status bit 48, which is upper-half bit 16) on the next clock and raises `dn_req` in that same cycle. The request fields are taken from the command word: `dn_we` from bit 63 (1 = write), `dn_size` from bits 62:61 (00 = byte, 01 = half-word, 11 = word), `dn_addr` from bits 55:32 and `dn_wdata` from bits 31:0.
- R3: While `dn_req` is high, all request fields stay stable. `dn_req` and busy drop on the clock after `dn_ack` or `dn_err` is seen.
- R4: An acknowledged read sets read-valid (status bit 49, upper-half bit 17) and places `dn_rdata` in status bits 31:0. An acknowledged write leaves read-valid clear and the data half zero. A new command clears both.
- R5: An error response from the downstream bus ends the transaction and sets status bit 52 (upper-half bit 20, in the downstream error group 0x09F00000).
- R6: If neither acknowledge nor error arrives within TIMEOUT cycles of busy (default 256), the request is dropped and status bit 53 (upper-half bit 21) is set.
- R7: A command written while busy is ignored. The request already in flight does not change, and status bit 54 (upper-half bit 22) is set.
- R8: Pulses on `mst_a_err[5:0]` set the sticky upper-half bits 15:10, which form group 0x0000FC00. Pulses on `mst_b_err[5:0]` set the sticky upper-half bits 7:2, which form group 0x000000FC. Bit i of each input maps to the lowest bit of its group plus i.
- R9: Writing zero to the status register clears all error flags, read-valid and the data half, and leaves busy unchanged. Writing any nonzero value to the status register has no effect.
- R10: When a transaction ends (by acknowledge, error or timeout), the last-status register takes the status value that becomes current on that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_sel`, combinational |
| dn_req | output | 1 | Downstream request, held until the transaction ends |
| dn_we | output | 1 | Downstream direction, 1 = write |
| dn_size | output | 2 | Downstream access size code |
| dn_addr | output | 24 | Downstream address |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_err | input | 1 | Downstream error response |
| dn_rdata | input | 32 | Downstream read data, valid with `dn_ack` |
| mst_a_err | input | 6 | Channel-A master error pulses |
| mst_b_err | input | 6 | Channel-B master error pulses |

## Verification
The main test sweeps every combination of the following:
- both directions;
- all three legal size codes;
- four address patterns (all-zero, all-one, alternating and walking);
- acknowledge latencies of zero to two cycles.

Write and read outcomes are separated by the read-valid bit and the data half. Every field of the command word is tied to its own request pin, which catches swapped or shifted fields.

Further tests cover each way a transaction can end, and each ending is told apart by its own status bit:
- an error response;
- a silent bus, timed out at exactly the TIMEOUT boundary.

The remaining tests cover the following:
- A colliding command must leave the in-flight request unchanged.
- Asymmetric master-error pulses must land in the right group at the right bit.
- Zero and nonzero writes to the status register must be told apart.

// File: rtl/cmd_bridge_target.sv
module cmd_bridge_target #(
  parameter int TIMEOUT = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        dn_req,
  output logic        dn_we,
  output logic [1:0]  dn_size,
  output logic [23:0] dn_addr,
  output logic [31:0] dn_wdata,
  input  logic        dn_ack,
  input  logic        dn_err,
  input  logic [31:0] dn_rdata,
  input  logic [5:0]  mst_a_err,
  input  logic [5:0]  mst_b_err
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);
  localparam int B_BUSY = 16;
  localparam int B_RVAL = 17;
  localparam int B_DNERR = 20;
  localparam int B_TMO = 21;
  localparam int B_COLL = 22;
  localparam logic [31:0] ERR_MASK = 32'h09F0_FCFC;

  logic [63:0]   cmd_q, last_q;
  logic [31:0]   st_hi, st_lo, nx_hi, nx_lo;
  logic [CW-1:0] cnt;

  wire busy     = st_hi[B_BUSY];
  wire cmd_wr   = reg_wr && (reg_sel == 2'd0);
  wire launch   = cmd_wr && !busy;
  wire collide  = cmd_wr && busy;
  wire stat_clr = reg_wr && (reg_sel == 2'd1) && (reg_wdata == 64'd0);
  wire tmo      = busy && !dn_ack && !dn_err && (cnt == CNT_LAST);
  wire done     = busy && (dn_ack || dn_err || tmo);

  assign dn_req   = busy;
  assign dn_we    = cmd_q[63];
  assign dn_size  = cmd_q[62:61];
  assign dn_addr  = cmd_q[55:32];
  assign dn_wdata = cmd_q[31:0];

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = cmd_q;
      2'd1:    reg_rdata = {st_hi, st_lo};
      2'd2:    reg_rdata = last_q;
      default: reg_rdata = 64'd0;
    endcase
  end

  always_comb begin
    nx_hi = st_hi;
    nx_lo = st_lo;
    if (stat_clr) begin
      nx_hi = nx_hi & ~(ERR_MASK | (32'd1 << B_RVAL));
      nx_lo = 32'd0;
    end
    if (launch) begin
      nx_hi[B_BUSY] = 1'b1;
      nx_hi[B_RVAL] = 1'b0;
      nx_lo = 32'd0;
    end
    if (collide) nx_hi[B_COLL] = 1'b1;
    nx_hi[15:10] = nx_hi[15:10] | mst_a_err;
    nx_hi[7:2]   = nx_hi[7:2] | mst_b_err;
    if (busy) begin
      if (dn_ack) begin
        nx_hi[B_BUSY] = 1'b0;
        if (!cmd_q[63]) begin
          nx_hi[B_RVAL] = 1'b1;
          nx_lo = dn_rdata;
        end
      end else if (dn_err) begin
        nx_hi[B_BUSY] = 1'b0;
        nx_hi[B_DNERR] = 1'b1;
      end else if (tmo) begin
        nx_hi[B_BUSY] = 1'b0;
        nx_hi[B_TMO] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= 64'd0;
      st_hi  <= 32'd0;
      st_lo  <= 32'd0;
      last_q <= 64'd0;
      cnt    <= '0;
    end else begin
      st_hi <= nx_hi;
      st_lo <= nx_lo;
      if (launch) cmd_q <= reg_wdata;
      if (done) last_q <= {nx_hi, nx_lo};
      if (launch) cnt <= '0;
      else if (busy && cnt != CNT_LAST) cnt <= cnt + 1'b1;
    end
  end

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0 && !dn_req) |=> (dn_req && dn_addr == $past(reg_wdata[55:32])));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && $past(dn_req)) |-> ($stable(dn_addr) && $stable(dn_wdata) && $stable(dn_we) && $stable(dn_size)));

  p_ack_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && (dn_ack || dn_err)) |=> !dn_req);

  p_rvalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && dn_ack && !dn_we) |=> (reg_sel != 2'd1 || (reg_rdata[49] && reg_rdata[31:0] == $past(dn_rdata))));

  p_dnerr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_ack && dn_err) |=> st_hi[B_DNERR]);

  p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0 && dn_req && !dn_ack && !dn_err) |=> (st_hi[B_COLL] && $stable(dn_addr)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1 && reg_wdata == 64'd0 && !dn_req && !reg_sel[1] && mst_a_err == 6'd0 && mst_b_err == 6'd0)
    |=> ((st_hi & ERR_MASK) == 32'd0 && st_lo == 32'd0));

  p_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && dn_ack) |=> (last_q == {st_hi, st_lo}));
endmodule

// File: tb/test_cmd_bridge_target.sv
module test_cmd_bridge_target;
  localparam int CLK_P = 10;
  localparam int TMO = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [63:0] reg_wdata = 64'd0;
  logic [63:0] reg_rdata;
  logic        dn_req, dn_we;
  logic [1:0]  dn_size;
  logic [23:0] dn_addr;
  logic [31:0] dn_wdata;
  logic        dn_ack = 1'b0;
  logic        dn_err = 1'b0;
  logic [31:0] dn_rdata = 32'd0;
  logic [5:0]  mst_a_err = 6'd0;
  logic [5:0]  mst_b_err = 6'd0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [31:0] exp_err = 32'd0;

  cmd_bridge_target #(.TIMEOUT(TMO)) i_cmd_bridge_target (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dn_req(dn_req),
    .dn_we(dn_we), .dn_size(dn_size), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_ack(dn_ack), .dn_err(dn_err), .dn_rdata(dn_rdata),
    .mst_a_err(mst_a_err), .mst_b_err(mst_b_err));

  always #(CLK_P/2) clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: cycle %0d reached, expected finish earlier", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [63:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    reg_wr = 1'b1;
    reg_sel = sel;
    reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  function automatic logic [63:0] mk_cmd(input logic we, input logic [1:0] sz,
                                         input logic [23:0] a, input logic [31:0] d);
    return {we, sz, 5'd0, a, d};
  endfunction

  task automatic txn(input logic we, input logic [1:0] sz, input logic [23:0] a,
                     input logic [31:0] d, input int lat, input logic [31:0] rdv);
    logic [63:0] v, st;
    wr(2'd0, mk_cmd(we, sz, a, d));
    chk("R2 req", {63'd0, dn_req}, 64'd1);
    chk("R2 fields", {dn_we, dn_size, dn_addr, dn_wdata}, {we, sz, a, d});
    rd(2'd1, v);
    chk("R2 busy", v, {exp_err | 32'h0001_0000, 32'd0});
    for (int k = 0; k < lat; k++) begin
      step();
      chk("R3 hold", {dn_req, dn_we, dn_size, dn_addr, dn_wdata}, {1'b1, we, sz, a, d});
    end
    dn_ack = 1'b1;
    dn_rdata = rdv;
    step();
    dn_ack = 1'b0;
    chk("R3 drop", {63'd0, dn_req}, 64'd0);
    rd(2'd1, st);
    chk("R4 status", st, we ? {exp_err, 32'd0} : {exp_err | 32'h0002_0000, rdv});
    rd(2'd2, v);
    chk("R10 last", v, st);
  endtask

  initial begin
    logic [63:0] v, keep;
    logic [23:0] addrs [4];
    logic [1:0]  sizes [3];
    addrs[0] = 24'h000000; addrs[1] = 24'hFFFFFF; addrs[2] = 24'hA5A5A5; addrs[3] = 24'h000001;
    sizes[0] = 2'b00; sizes[1] = 2'b01; sizes[2] = 2'b11;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], v);
      chk("R1 reset reg", v, 64'd0);
    end
    chk("R1 reset req", {63'd0, dn_req}, 64'd0);

    for (int w = 0; w < 2; w++)
      for (int z = 0; z < 3; z++)
        for (int ai = 0; ai < 4; ai++)
          for (int l = 0; l < 3; l++) begin
            logic [31:0] dd, rr;
            dd = 32'h1357_9BDF ^ (32'(ai) << (8 * z)) ^ 32'(l * 77);
            rr = {8'(z), addrs[ai]} ^ 32'(w * 1000 + l);
            txn(w[0], sizes[z], addrs[ai] << (l * 4), dd, l, rr);
          end

    rd(2'd0, v);
    chk("R1 cmd readback", v[55:32], {addrs[3] << 8});

    rd(2'd2, keep);
    wr(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd2, v);
    chk("R1 sel2 write ignored", v, keep);
    rd(2'd1, keep);
    wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd1, v);
    chk("R1 sel3 write ignored", v, keep);
    rd(2'd3, v);
    chk("R1 sel3 zero", v, 64'd0);

    mst_a_err = 6'b100001;
    mst_b_err = 6'b000110;
    step();
    mst_a_err = 6'd0;
    mst_b_err = 6'd0;
    exp_err = (32'(6'b100001) << 10) | (32'(6'b000110) << 2);
    rd(2'd1, v);
    chk("R8 groups", {v[63:32] & 32'h0000_FCFC, 32'd0}, {exp_err, 32'd0});

    wr(2'd1, 64'd5);
    rd(2'd1, v);
    chk("R9 nonzero ignored", v[63:32] & 32'h0000_FCFC, exp_err);
    wr(2'd1, 64'd0);
    exp_err = 32'd0;
    rd(2'd1, v);
    chk("R9 clear", v, 64'd0);

    wr(2'd0, mk_cmd(1'b0, 2'b11, 24'h123456, 32'd0));
    wr(2'd0, mk_cmd(1'b1, 2'b00, 24'h654321, 32'hDEAD_BEEF));
    chk("R7 unchanged", {dn_req, dn_we, dn_size, dn_addr}, {1'b1, 1'b0, 2'b11, 24'h123456});
    rd(2'd1, v);
    chk("R7 flag", v, {32'h0041_0000, 32'd0});
    wr(2'd1, 64'd0);
    rd(2'd1, v);
    chk("R9 busy kept", v, {32'h0001_0000, 32'd0});
    dn_err = 1'b1;
    step();
    dn_err = 1'b0;
    chk("R5 drop", {63'd0, dn_req}, 64'd0);
    rd(2'd1, v);
    chk("R5 flag", v, {32'h0010_0000, 32'd0});
    rd(2'd2, keep);
    chk("R10 last on error", keep, v);
    wr(2'd1, 64'd0);

    wr(2'd0, mk_cmd(1'b0, 2'b01, 24'h00BEEF, 32'd0));
    for (int k = 0; k < TMO - 1; k++) step();
    chk("R6 still waiting", {63'd0, dn_req}, 64'd1);
    step();
    chk("R6 timed out", {63'd0, dn_req}, 64'd0);
    rd(2'd1, v);
    chk("R6 flag", v, {32'h0020_0000, 32'd0});
    rd(2'd2, keep);
    chk("R10 last on timeout", keep, v);
    dn_ack = 1'b1;
    step();
    dn_ack = 1'b0;
    rd(2'd1, v);
    chk("R3 stray ack ignored", v, {32'h0020_0000, 32'd0});

    summary();
  end
endmodule